// File: doc/BRIEF.md
# Debug Port Mode-Switch Detector

This block watches the single data line that a debug port shares between a four-wire boundary-scan protocol and a two-wire serial protocol. It samples that line on every rising edge of the debug clock and decides which of the two protocols is active. After power-on reset the port is in JTAG mode. A host changes the mode by holding the line high for a long run of clocks, which acts as a line reset. The host then sends a 16-bit signature, least significant bit first. One signature selects serial-wire mode and the other returns the port to JTAG. The detector accepts either signature in either mode, because a host that has lost contact cannot know which mode the port is in.

The block is built around a three-state controller. `ST_HUNT` waits for the high-run counter to saturate. It moves to `ST_ARMED` when the run qualifies and the line is still high. It moves straight to `ST_SHIFT` when the run qualifies and the current sample is already low. `ST_ARMED` stays put while the line stays high and moves to `ST_SHIFT` on the first low sample, which is bit 0 of the window. `ST_SHIFT` collects the remaining 15 bits and always returns to `ST_HUNT` on the 16th bit, whether or not the window matched. A match drives a one-cycle event pulse for its direction and updates the mode register in the same edge. The high-run counter is held at zero while a window is being shifted, so every later signature needs a fresh run that starts after the window ends.

Top module: `dbg_proto_switch`

## Requirements
- R1: While `rst_n` is low, and after it is released, `mode_swire` is 0 (JTAG), `line_rst` is 0 and both event outputs are 0.
- R2: `line_rst` goes to 1 after the edge that samples the 50th consecutive high value of `dio_in`. The run counter saturates, so `line_rst` stays 1 for any longer run, including a run of several hundred cycles. The first low sample clears `line_rst`.
- R3: After a qualifying run, the 16 bits 0xE79E sent LSB first set `mode_swire` to 1. `evt_to_swire` is 1 for exactly the one cycle that follows the edge sampling the 16th bit.
- R4: After a qualifying run, the 16 bits 0xE73C sent LSB first set `mode_swire` to 0. `evt_to_jtag` is 1 for exactly the one cycle that follows the edge sampling the 16th bit.
- R5: A signature that follows a run of 49 or fewer high samples produces no event and leaves the mode unchanged.
- R6: A 16-bit window that matches neither signature produces no event and leaves the mode unchanged. A valid signature sent without a new run of 50 high samples after that window is also ignored.
- R7: A signature that requests the mode already active still produces its event pulse, and `mode_swire` keeps its value.
- R8: `line_rst` is 0 for the whole 16-bit window. The run counter starts again from zero after the window, so a signature sent after only 49 high samples that follow a window is ignored.
- R9: The two event outputs are never 1 together. `mode_swire` changes only in a cycle where an event output is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Debug clock; the data line is sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| dio_in | input | 1 | Shared mode/data line of the debug port |
| mode_swire | output | 1 | Current mode: 0 = JTAG, 1 = serial-wire |
| line_rst | output | 1 | 1 while the current high run has reached 50 cycles |
| evt_to_swire | output | 1 | One-cycle pulse when the serial-wire signature is accepted |
| evt_to_jtag | output | 1 | One-cycle pulse when the JTAG signature is accepted |

## Verification
The bench sweeps the run length from 45 to 55 cycles in front of a signature. A design that counts off by one would accept after 49 highs or reject after exactly 50. The bench flips each of the 16 bits of both signatures one at a time and then sends a valid signature with no fresh run. A design that compared a sliding window, or kept the run armed after a failed window, would fire an event there. It also sends each signature while its mode is already active, which catches designs that gate the pulse on a mode change. It drives a 300-cycle run, which exposes a counter that wraps, and it applies a reset while in serial-wire mode.

// File: rtl/dps_pkg.sv
package dps_pkg;

    // Controller states of the detector
    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,   // waiting for a qualifying high run
        ST_ARMED = 2'd1,   // run qualified, line still high
        ST_SHIFT = 2'd2    // collecting the 16-bit signature window
    } dps_state_e;

    // Operating mode of the debug port
    typedef enum logic {
        MODE_JTAG  = 1'b0,
        MODE_SWIRE = 1'b1
    } dps_mode_e;

endpackage

// File: rtl/dps_run_counter.sv
module dps_run_counter #(
    parameter int RUN_MIN = 50,
    parameter int CNT_W   = $clog2(RUN_MIN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    input  logic clr,
    output logic sat
);

    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(RUN_MIN);

    logic [CNT_W-1:0] cnt_q;

    // Count consecutive high samples; hold at the top value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || !line_in) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_TOP) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign sat = (cnt_q == CNT_TOP);

    // R2: a saturated run stays saturated while the line stays high
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sat && line_in && !clr) |=> sat);

    // R2: a low sample ends the run
    run_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_in) |=> !sat);

endmodule

// File: rtl/dps_code_shifter.sv
module dps_code_shifter #(
    parameter int CODE_W = 16,
    parameter int BCNT_W = $clog2(CODE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    input  logic              capture,
    input  logic              start,
    output logic [CODE_W-1:0] word_nxt,
    output logic              last_bit
);

    localparam logic [BCNT_W-1:0] LAST_IDX = BCNT_W'(CODE_W - 1);

    logic [CODE_W-1:0] sh_q;
    logic [BCNT_W-1:0] bcnt_q;

    // Bits arrive LSB first: each new bit enters at the top and moves down
    assign word_nxt = {bit_in, sh_q[CODE_W-1:1]};

    // The bit now on the line completes the window
    assign last_bit = (bcnt_q == LAST_IDX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            bcnt_q <= '0;
        end else if (capture) begin
            sh_q   <= word_nxt;
            bcnt_q <= start ? BCNT_W'(1) : bcnt_q + BCNT_W'(1);
        end
    end

    // R6: a window that opens must begin counting from its first bit
    win_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && start) |=> (bcnt_q == BCNT_W'(1)));

endmodule

// File: rtl/dps_ctrl.sv
module dps_ctrl
    import dps_pkg::*;
#(
    parameter int              CODE_W       = 16,
    parameter logic [CODE_W-1:0] CODE_TO_SW   = 16'hE79E,
    parameter logic [CODE_W-1:0] CODE_TO_JTAG = 16'hE73C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_in,
    input  logic              sat,
    input  logic [CODE_W-1:0] word_nxt,
    input  logic              last_bit,
    output logic              capture,
    output logic              start,
    output logic              clr,
    output dps_mode_e         mode,
    output logic              evt_sw,
    output logic              evt_jt
);

    dps_state_e st_q, st_nxt;
    logic       hit_sw, hit_jt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_HUNT;
        end else begin
            st_q <= st_nxt;
        end
    end

    // Next state and window control
    always_comb begin
        st_nxt  = st_q;
        capture = 1'b0;
        start   = 1'b0;
        unique case (st_q)
            ST_HUNT: begin
                if (sat && !line_in) begin
                    capture = 1'b1;
                    start   = 1'b1;
                    st_nxt  = ST_SHIFT;
                end else if (sat) begin
                    st_nxt = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (!line_in) begin
                    capture = 1'b1;
                    start   = 1'b1;
                    st_nxt  = ST_SHIFT;
                end else if (!sat) begin
                    st_nxt = ST_HUNT;
                end
            end
            ST_SHIFT: begin
                capture = 1'b1;
                if (last_bit) begin
                    st_nxt = ST_HUNT;
                end
            end
            default: begin
                st_nxt = ST_HUNT;
            end
        endcase
    end

    // Run counter is held at zero while a window is open
    assign clr = (st_q == ST_SHIFT);

    // Signature compare on the completing bit
    assign hit_sw = (st_q == ST_SHIFT) && last_bit && (word_nxt == CODE_TO_SW);
    assign hit_jt = (st_q == ST_SHIFT) && last_bit && (word_nxt == CODE_TO_JTAG);

    // Registered outputs: mode and event pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode   <= MODE_JTAG;
            evt_sw <= 1'b0;
            evt_jt <= 1'b0;
        end else begin
            evt_sw <= hit_sw;
            evt_jt <= hit_jt;
            if (hit_sw) begin
                mode <= MODE_SWIRE;
            end else if (hit_jt) begin
                mode <= MODE_JTAG;
            end
        end
    end

    // R8
    shift_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SHIFT) |-> !sat);

    // R9
    evt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt_sw && evt_jt));

    // R3
    sw_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_sw |=> !evt_sw);

    // R4
    jt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_jt |=> !evt_jt);

    // R3
    sw_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_sw |-> (mode == MODE_SWIRE));

    // R4
    jt_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_jt |-> (mode == MODE_JTAG));

    // R9
    mode_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != $past(mode)) |-> (evt_sw || evt_jt));

    // R6
    shift_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_SHIFT) && last_bit) |=> (st_q == ST_HUNT));

endmodule

// File: rtl/dbg_proto_switch.sv
module dbg_proto_switch
    import dps_pkg::*;
#(
    parameter int                RUN_MIN      = 50,
    parameter int                CODE_W       = 16,
    parameter logic [CODE_W-1:0] CODE_TO_SW   = 16'hE79E,
    parameter logic [CODE_W-1:0] CODE_TO_JTAG = 16'hE73C
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dio_in,
    output logic mode_swire,
    output logic line_rst,
    output logic evt_to_swire,
    output logic evt_to_jtag
);

    localparam int CNT_W  = $clog2(RUN_MIN + 1);
    localparam int BCNT_W = $clog2(CODE_W);

    logic              sat;
    logic              clr;
    logic              capture;
    logic              start;
    logic              last_bit;
    logic [CODE_W-1:0] word_nxt;
    dps_mode_e         mode;

    dps_run_counter #(
        .RUN_MIN (RUN_MIN),
        .CNT_W   (CNT_W)
    ) u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (dio_in),
        .clr     (clr),
        .sat     (sat)
    );

    dps_code_shifter #(
        .CODE_W (CODE_W),
        .BCNT_W (BCNT_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_in   (dio_in),
        .capture  (capture),
        .start    (start),
        .word_nxt (word_nxt),
        .last_bit (last_bit)
    );

    dps_ctrl #(
        .CODE_W       (CODE_W),
        .CODE_TO_SW   (CODE_TO_SW),
        .CODE_TO_JTAG (CODE_TO_JTAG)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_in  (dio_in),
        .sat      (sat),
        .word_nxt (word_nxt),
        .last_bit (last_bit),
        .capture  (capture),
        .start    (start),
        .clr      (clr),
        .mode     (mode),
        .evt_sw   (evt_to_swire),
        .evt_jt   (evt_to_jtag)
    );

    assign mode_swire = (mode == MODE_SWIRE);
    assign line_rst   = sat;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (!mode_swire && !line_rst && !evt_to_swire && !evt_to_jtag));

    // R9
    evt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({evt_to_swire, evt_to_jtag}));

endmodule

// File: tb/sim_dbg_proto_switch.sv
module sim_dbg_proto_switch;

    localparam logic [15:0] SIG_SW = 16'hE79E;
    localparam logic [15:0] SIG_JT = 16'hE73C;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic dio   = 1'b1;
    logic mode_swire, line_rst, evt_to_swire, evt_to_jtag;

    int   n_chk  = 0;
    int   n_fail = 0;
    logic exp_mode = 1'b0;
    logic seen_sw, seen_jt;

    always #4 clk = ~clk;

    dbg_proto_switch u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .dio_in       (dio),
        .mode_swire   (mode_swire),
        .line_rst     (line_rst),
        .evt_to_swire (evt_to_swire),
        .evt_to_jtag  (evt_to_jtag)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one sample, let the rising edge take it, observe at the falling edge
    task automatic tick(input logic b);
        dio = b;
        @(posedge clk);
        @(negedge clk);
        if (evt_to_swire) seen_sw = 1'b1;
        if (evt_to_jtag)  seen_jt = 1'b1;
    endtask

    task automatic run_high(input int n);
        for (int i = 0; i < n; i++) tick(1'b1);
    endtask

    task automatic send_code(input logic [15:0] w, output logic l_sw, output logic l_jt,
                             output logic early, output logic lr_hi);
        early = 1'b0;
        lr_hi = 1'b0;
        for (int i = 0; i < 16; i++) begin
            tick(w[i]);
            if (i < 15 && (evt_to_swire || evt_to_jtag)) early = 1'b1;
            if (line_rst) lr_hi = 1'b1;
        end
        l_sw = evt_to_swire;
        l_jt = evt_to_jtag;
    endtask

    // High run (added to a prior run of known length), then a signature
    task automatic do_code(input int run, input int prior, input logic [15:0] w,
                           input logic e_sw, input logic e_jt, input string req);
        logic l_sw, l_jt, early, lr_hi;
        run_high(run);
        chk(line_rst == ((run + prior) >= 50), "R2 line_rst before code", line_rst, (run + prior) >= 50);
        send_code(w, l_sw, l_jt, early, lr_hi);
        chk(l_sw == e_sw, {req, " evt_to_swire"}, l_sw, e_sw);
        chk(l_jt == e_jt, {req, " evt_to_jtag"}, l_jt, e_jt);
        chk(!early, "R9 no event inside window", early, 0);
        chk(!lr_hi, "R8 line_rst low in window", lr_hi, 0);
        if (e_sw) exp_mode = 1'b1;
        if (e_jt) exp_mode = 1'b0;
        chk(mode_swire == exp_mode, {req, " mode"}, mode_swire, exp_mode);
        tick(1'b1);
        chk(!evt_to_swire && !evt_to_jtag, "R9 single-cycle pulse", {evt_to_swire, evt_to_jtag}, 0);
        chk(mode_swire == exp_mode, "R9 mode steady after pulse", mode_swire, exp_mode);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic bad;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(!mode_swire && !line_rst && !evt_to_swire && !evt_to_jtag, "R1 in reset",
            {mode_swire, line_rst, evt_to_swire, evt_to_jtag}, 0);
        rst_n = 1'b1;
        tick(1'b0);
        chk(!mode_swire && !line_rst, "R1 after release", {mode_swire, line_rst}, 0);

        // R3 R5 R4 R7: sweep the qualifying run length
        for (int n = 45; n <= 55; n++) begin
            tick(1'b0);
            do_code(n, 0, SIG_SW, (n >= 50), 1'b0, "R3 R5 sweep");
            do_code(60, 0, SIG_JT, 1'b0, 1'b1, "R4 R7 restore");
        end

        // R7: request the active mode in each mode
        do_code(50, 0, SIG_SW, 1'b1, 1'b0, "R3 enter swire");
        do_code(50, 0, SIG_SW, 1'b1, 1'b0, "R7 repeat swire");
        do_code(50, 0, SIG_JT, 1'b0, 1'b1, "R4 enter jtag");
        do_code(70, 0, SIG_JT, 1'b0, 1'b1, "R7 repeat jtag");

        // R6: every single-bit corruption of both signatures
        for (int c = 0; c < 2; c++) begin
            for (int i = 0; i < 16; i++) begin
                logic [15:0] w;
                logic l_sw, l_jt, early, lr_hi;
                w = (c == 0 ? SIG_SW : SIG_JT) ^ (16'h1 << i);
                tick(1'b0);
                run_high(50);
                seen_sw = 1'b0;
                seen_jt = 1'b0;
                send_code(w, l_sw, l_jt, early, lr_hi);
                run_high(20);
                chk(!seen_sw && !seen_jt, "R6 corrupted window", {seen_sw, seen_jt}, 0);
                chk(mode_swire == exp_mode, "R6 mode kept", mode_swire, exp_mode);
                do_code(0, 20, SIG_SW, 1'b0, 1'b0, "R6 no fresh run");
            end
        end

        // R8: after a window only a fresh full run re-arms
        tick(1'b0);
        do_code(50, 0, SIG_SW, 1'b1, 1'b0, "R8 first");
        do_code(48, 1, SIG_JT, 1'b0, 1'b0, "R8 49 after window");
        do_code(50, 0, SIG_JT, 1'b0, 1'b1, "R8 50 after window");

        // R2: long run saturates and does not wrap
        tick(1'b0);
        bad = 1'b0;
        for (int i = 0; i < 300; i++) begin
            tick(1'b1);
            if (line_rst != (i >= 49)) bad = 1'b1;
        end
        chk(!bad, "R2 saturating run", bad, 0);
        do_code(0, 300, SIG_SW, 1'b1, 1'b0, "R2 R3 after long run");
        run_high(60);
        tick(1'b0);
        chk(!line_rst, "R2 low clears", line_rst, 0);

        // R1: reset while in serial-wire mode
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!mode_swire && !line_rst, "R1 reset from swire", {mode_swire, line_rst}, 0);
        rst_n = 1'b1;
        exp_mode = 1'b0;
        tick(1'b1);
        chk(!mode_swire, "R1 jtag after reset", mode_swire, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule